// File: doc/BRIEF.md
# Bounce-Free Switch Latch

This block turns the two throws of a single-pole double-throw switch into one clean level. Each throw arrives as an active-low contact line. An open contact reads as logic high. Both lines are first brought into the clock domain through a short flop chain. A clocked set/clear storage element then drives a true output and a complementary output.

There is no counter and no timer. Bounce on the throw that has just closed only produces brief open (high) readings, and a high reading holds the stored value, so the output changes once per throw.

When both throws read closed, both outputs go high and a flag is raised. If both then open in the same cycle, the element falls back to the last value it held legally, so the result is always defined. A synchronous active-low reset clears the element and returns the synchronizer chains to the open level.

Top module: `contact_latch`

## Requirements
- R1: A synchronized low on `set_in_n` while `clr_in_n` reads high drives `q` to 1 and `qn` to 0.
- R2: A synchronized low on `clr_in_n` while `set_in_n` reads high drives `q` to 0 and `qn` to 1.
- R3: While both synchronized inputs read high and the previous state was legal, `q` and `qn` keep their values.
- R4: While both synchronized inputs read low, `q` and `qn` are both 1 and `illegal_flag` is 1.
- R5: When both inputs go from low to high in the same cycle, the outputs settle to the last value of `q` set by a legal set or clear, with `qn` as its complement. After reset that value is 0.
- R6: `illegal_flag` is 1 exactly when `q` and `qn` are both 1. In every other cycle `qn` equals the inverse of `q`.
- R7: Any number of open/closed toggles on the contact that last closed, while the other contact stays open, leaves the outputs unchanged after the first closure.
- R8: An input change is seen at the outputs after SYNC_STAGES+1 rising clock edges (3 with the default of 2). The outputs still show the old value one edge earlier.
- R9: While `rst_n` is sampled low, the next edge gives `q`=0, `qn`=1 and `illegal_flag`=0 whatever the inputs are. The synchronizer chains reset to the open (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_in_n | input | 1 | Active-low contact of the throw that sets the output |
| clr_in_n | input | 1 | Active-low contact of the throw that clears the output |
| q | output | 1 | Stored level |
| qn | output | 1 | Complement of `q`; also 1 in the illegal state |
| illegal_flag | output | 1 | High while both contacts read closed |

## Verification
The checker looks at the synchronized contact levels on every cycle. It confirms the set, clear and both-closed responses one edge later, the hold while both contacts read open, the tie between the flag and the both-high outputs, and the reset response.

Some behaviour cannot be seen one cycle at a time, so only the bench scenarios show it:
- the fall-back after a joint release to the value held before the illegal episode;
- the pipeline latency from the pins;
- that long bounce bursts leave the output alone.

// File: rtl/cl_pkg.sv
// Package: shared command encoding for the bounce-free switch latch.
// Assumes active-low contact levels, already synchronized, as decoder input.
package cl_pkg;

    // Decoded request from the two synchronized contact levels
    typedef enum logic [1:0] {
        CMD_HOLD = 2'b00,   // both contacts open
        CMD_SET  = 2'b01,   // only the set throw closed
        CMD_CLR  = 2'b10,   // only the clear throw closed
        CMD_BOTH = 2'b11    // both closed: illegal combination
    } cl_cmd_e;

    // Map active-low levels to a request
    function automatic cl_cmd_e cl_decode_levels(input logic set_n, input logic clr_n);
        logic [1:0] act;
        act = {~clr_n, ~set_n};
        case (act)
            2'b01:   return CMD_SET;
            2'b10:   return CMD_CLR;
            2'b11:   return CMD_BOTH;
            default: return CMD_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/cl_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; on reset every stage takes RESET_VAL.
module cl_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the chain, or preload the open level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/cl_decode.sv
// Module: turns the two synchronized active-low levels into a request.
// Assumes both inputs are already in the clk domain; purely combinational.
module cl_decode
    import cl_pkg::*;
(
    input  logic    set_s_n,
    input  logic    clr_s_n,
    output cl_cmd_e cmd
);

    // Decode contact levels
    always_comb begin
        cmd = cl_decode_levels(set_s_n, clr_s_n);
    end

endmodule

// File: rtl/cl_core.sv
// Module: clocked set/clear storage element with a defined illegal state.
// Assumes one request per cycle. After a both-closed episode, a hold
// request restores the last legally stored value.
module cl_core
    import cl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cl_cmd_e cmd,
    output logic    q,
    output logic    qn,
    output logic    illegal_flag
);

    logic q_r, qn_r, ill_r, legal_r;

    // Update the stored pair, the illegal marker and the last legal value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r     <= 1'b0;
            qn_r    <= 1'b1;
            ill_r   <= 1'b0;
            legal_r <= 1'b0;
        end else begin
            case (cmd)
                CMD_SET: begin
                    q_r     <= 1'b1;
                    qn_r    <= 1'b0;
                    ill_r   <= 1'b0;
                    legal_r <= 1'b1;
                end
                CMD_CLR: begin
                    q_r     <= 1'b0;
                    qn_r    <= 1'b1;
                    ill_r   <= 1'b0;
                    legal_r <= 1'b0;
                end
                CMD_BOTH: begin
                    q_r   <= 1'b1;
                    qn_r  <= 1'b1;
                    ill_r <= 1'b1;
                end
                default: begin
                    if (ill_r) begin
                        q_r   <= legal_r;
                        qn_r  <= ~legal_r;
                        ill_r <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign q            = q_r;
    assign qn           = qn_r;
    assign illegal_flag = ill_r;

endmodule

// File: rtl/contact_latch.sv
// Module: bounce-free switch latch top.
// Assumes both contact lines are asynchronous, active low, with open = high.
module contact_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in_n,
    input  logic clr_in_n,
    output logic q,
    output logic qn,
    output logic illegal_flag
);

    import cl_pkg::*;

    localparam int NUM_CONTACTS = 2;

    logic [NUM_CONTACTS-1:0] raw_n;
    logic [NUM_CONTACTS-1:0] synced_n;
    logic                    set_sync_n;
    logic                    clr_sync_n;
    cl_cmd_e                 cmd;

    assign raw_n = {clr_in_n, set_in_n};

    // One synchronizer per contact line
    for (genvar g = 0; g < NUM_CONTACTS; g++) begin : g_sync
        cl_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_async(raw_n[g]),
            .d_sync (synced_n[g])
        );
    end

    assign set_sync_n = synced_n[0];
    assign clr_sync_n = synced_n[1];

    cl_decode u_dec (
        .set_s_n(set_sync_n),
        .clr_s_n(clr_sync_n),
        .cmd    (cmd)
    );

    cl_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .q           (q),
        .qn          (qn),
        .illegal_flag(illegal_flag)
    );

endmodule

// File: rtl/cl_checker.sv
// Module: property checker for contact_latch, attached by bind.
// Assumes access to the synchronized contact levels inside the top.
module cl_checker (
    input logic clk,
    input logic rst_n,
    input logic set_s_n,
    input logic clr_s_n,
    input logic q,
    input logic qn,
    input logic illegal_flag
);

    // R1: set request yields q=1, qn=0
    a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_s_n && clr_s_n) |=> (q && !qn));

    // R2: clear request yields q=0, qn=1
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_s_n && !clr_s_n) |=> (!q && qn));

    // R3: both open from a legal state holds q
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_s_n && clr_s_n && !illegal_flag) |=> $stable(q));

    // R4: both closed gives both outputs high and the flag
    a_r4_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_s_n && !clr_s_n) |=> (q && qn && illegal_flag));

    // R5: a joint release leaves the illegal state
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_flag && set_s_n && clr_s_n) |=> (q != qn) && !illegal_flag);

    // R6: flag tracks the both-high pair; otherwise outputs complement
    a_r6_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag == (q && qn));

    a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_flag |-> (q != qn));

    // R9: reset dominates the next edge
    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> (!q && qn && !illegal_flag));

endmodule

bind contact_latch cl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_s_n     (set_sync_n),
    .clr_s_n     (clr_sync_n),
    .q           (q),
    .qn          (qn),
    .illegal_flag(illegal_flag)
);

// File: tb/contact_latch_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard for contact_latch. The driver runs a per-cycle model
// built from the requirements and queues expected outputs with a due cycle.
// The monitor compares them after each rising edge.
module contact_latch_tb;

    localparam int SYNC_STAGES = 2;
    localparam int LAT         = SYNC_STAGES + 1;

    typedef struct {
        int    due;
        logic  q;
        logic  qn;
        logic  fl;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_n = 1'b1;
    logic clr_n = 1'b1;
    logic q, qn, illegal_flag;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // model state
    logic mq = 1'b0, mqn = 1'b1, mfl = 1'b0, mlast = 1'b0;

    contact_latch #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_in_n(set_n), .clr_in_n(clr_n),
        .q(q), .qn(qn), .illegal_flag(illegal_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Model one cycle of the latch from the requirement rules
    task automatic model_step(input logic s, input logic c);
        if (!s && c) begin
            mq = 1; mqn = 0; mfl = 0; mlast = 1;
        end else if (s && !c) begin
            mq = 0; mqn = 1; mfl = 0; mlast = 0;
        end else if (!s && !c) begin
            mq = 1; mqn = 1; mfl = 1;
        end else if (mfl) begin
            mq = mlast; mqn = ~mlast; mfl = 0;
        end
    endtask

    // Drive one input pattern for a number of cycles and queue the results
    task automatic step(input logic s, input logic c, input int hold, input string tag);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            set_n = s;
            clr_n = c;
            model_step(s, c);
            sb.push_back('{cyc + LAT, mq, mqn, mfl, tag});
        end
    endtask

    // Drain the pipeline, then hold reset with set closed (R9)
    task automatic do_reset(input int cycles);
        repeat (LAT + 1) @(negedge clk);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            set_n = 1'b0;
            clr_n = 1'b1;
            mq = 0; mqn = 1; mfl = 0; mlast = 0;
            sb.push_back('{cyc + 1, 1'b0, 1'b1, 1'b0, "R9 reset dominates"});
        end
        @(negedge clk);
        rst_n = 1'b1;
        set_n = 1'b1;
    endtask

    // Monitor: compare queued expectations as they fall due
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (e.due != cyc || q !== e.q || qn !== e.qn || illegal_flag !== e.fl) begin
                    n_bad++;
                    $display("FAIL %s @%0d: q=%b qn=%b flag=%b expected q=%b qn=%b flag=%b",
                             e.tag, cyc, q, qn, illegal_flag, e.q, e.qn, e.fl);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state (R9)
        repeat (3) @(negedge clk);
        sb.push_back('{cyc + 1, 1'b0, 1'b1, 1'b0, "R9 reset state"});
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 1, 5, "R3 hold after reset");
        step(0, 1, 4, "R1 R8 set");
        step(1, 1, 4, "R3 hold high");
        step(1, 0, 4, "R2 R8 clear");
        step(1, 1, 3, "R3 hold low");

        // bounce on the set throw (R7)
        step(0, 1, 1, "R7 set close");
        for (int k = 0; k < 6; k++) begin
            step(1, 1, 1, "R7 set bounce open");
            step(0, 1, k % 3 + 1, "R7 set bounce close");
        end
        step(1, 1, 4, "R7 set released");

        // bounce on the clear throw (R7)
        step(1, 0, 2, "R7 clr close");
        for (int k = 0; k < 5; k++) begin
            step(1, 1, k % 2 + 1, "R7 clr bounce open");
            step(1, 0, 1, "R7 clr bounce close");
        end
        step(1, 1, 3, "R7 clr released");

        // illegal combination and joint release to last legal 1 (R4 R5 R6)
        step(0, 1, 3, "R1 pre-illegal set");
        step(0, 0, 4, "R4 R6 both closed");
        step(1, 1, 4, "R5 joint release to 1");

        // joint release to last legal 0
        step(1, 0, 3, "R2 pre-illegal clear");
        step(0, 0, 2, "R4 both closed again");
        step(1, 1, 3, "R5 joint release to 0");

        // leave the illegal state one throw at a time
        step(0, 0, 2, "R4 both closed");
        step(0, 1, 3, "R1 clear throw opens first");
        step(0, 0, 1, "R4 single-cycle both closed");
        step(1, 0, 3, "R2 set throw opens first");

        // reset mid-operation, then last-legal falls back to 0 (R5 R9)
        step(0, 1, 3, "R1 before reset");
        do_reset(3);
        step(1, 1, 4, "R9 hold after reset");
        step(0, 0, 2, "R4 illegal after reset");
        step(1, 1, 3, "R5 release after reset gives 0");

        repeat (LAT + 2) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d expectations never fell due, expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule